// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Daisy-Chained Grant

The block arbitrates interrupt requests from a row of device slots. Each slot raises a request tagged with one of four urgency levels, 4 (lowest) to 7 (highest). The block compares the pending levels against the 3-bit processor priority. It then drives exactly one grant line, the one for the highest level that lies strictly above that priority. The grant line runs along a chain of slot cells, with slot 0 nearest the processor. A slot that is requesting at the granted level absorbs the grant. Any other slot passes it on to the next slot.

The slot that holds the grant keeps it even after it withdraws its request. The device then presents its vector address with a one-cycle valid strobe. The block reports that vector and the granted level to the core as a single-cycle pulse, then releases the grant. If nobody answers within a parameterised number of cycles, the block raises a bus-error trap request. This request carries the fixed vector address octal 004. Requests that are not granted simply stay pending.

Top module: `irq_chain_arbiter`

## Requirements
- R1: After reset, `grant_o`, `dev_gnt_o`, `vec_valid_o` and `bus_err_o` are all zero.
- R2: A level L (4..7) is granted only when L is strictly greater than `cpu_prio_i` as sampled in the cycle before the grant appears. At priority 7 no grant is ever issued. Grant bit k of `grant_o` stands for level 4+k.
- R3: When several levels qualify, only the highest is granted, and at most one bit of `grant_o` is set at a time.
- R4: A request that is refused stays pending. It is granted one cycle after the priority falls below its level.
- R5: Among slots requesting at the granted level, the slot with the lowest index wins. Only that slot sees `dev_gnt_o` set.
- R6: A slot that is idle, or that requests at another level, forwards the grant unchanged. Level code c on `dev_lvl_i` means level 4+c.
- R7: Once a slot has held the grant across a clock edge, it keeps absorbing the grant after dropping its request. A later slot at the same level does not receive it.
- R8: When the holding slot asserts its `dev_vld_i` bit, then in the next cycle `vec_valid_o` pulses for one cycle, with `vec_addr_o` equal to that slot's vector and `vec_lvl_o` equal to the granted level. In that same cycle `grant_o` is zero.
- R9: If no slot answers, the grant stays active for exactly TIMEOUT cycles. In the following cycle `bus_err_o` and `vec_valid_o` pulse together, with `vec_addr_o` = 4 (octal 004), and the grant is released.
- R10: While granted, `grant_o` holds its value until an answer or a timeout, even if `cpu_prio_i` rises.
- R11: After each answer or timeout, `grant_o` is zero for at least one cycle before any further grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_prio_i | input | 3 | Current processor priority 0..7 |
| dev_req_i | input | N_DEV | Per-slot interrupt request |
| dev_lvl_i | input | 2*N_DEV | Per-slot level code, level = 4 + code |
| dev_vld_i | input | N_DEV | Per-slot vector-valid strobe |
| dev_vec_i | input | VEC_W*N_DEV | Per-slot vector address |
| dev_gnt_o | output | N_DEV | Slot currently holding the grant |
| grant_o | output | 4 | Grant lines, bit k for level 4+k |
| vec_valid_o | output | 1 | One-cycle pulse, vector reported |
| vec_addr_o | output | VEC_W | Reported vector address |
| vec_lvl_o | output | 3 | Level that was granted |
| bus_err_o | output | 1 | One-cycle bus-error trap request |

## Verification
The bench builds the block with four slots and TIMEOUT of 8 cycles. With these values, a slot at the head of the chain, slots in the middle and the slot at the tail can all compete at one level. A whole timeout window also stays short enough to step through cycle by cycle. That makes it possible to check the exact cycle of the bus-error pulse in two cases. In the first, a slot holds the grant and stays silent. In the second, the requester withdraws before it latches the grant, so the grant falls off the end of the chain.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
  localparam int unsigned LVL_N    = 4;
  localparam int unsigned LVL_BASE = 4;
  localparam int unsigned CODE_W   = 2;
  localparam int unsigned PRIO_W   = 3;
  localparam logic [15:0] BUS_ERR_VEC = 16'o004;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_GRANT = 1'b1} arb_state_e;

  function automatic logic [PRIO_W-1:0] code_to_level(input logic [CODE_W-1:0] c);
    return PRIO_W'(LVL_BASE) + PRIO_W'(c);
  endfunction
endpackage

// File: rtl/irq_level_select.sv
`timescale 1ns/1ps
module irq_level_select
  import irq_arb_pkg::*;
(
  input  logic [LVL_N-1:0]  line_req_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic              any_o,
  output logic [CODE_W-1:0] top_code_o
);
  logic [LVL_N-1:0] qual;

  for (genvar c = 0; c < LVL_N; c++) begin : g_qual
    assign qual[c] = line_req_i[c] && (PRIO_W'(LVL_BASE + c) > prio_i);
  end

  // ascending scan: highest qualifying level wins
  always_comb begin
    any_o      = 1'b0;
    top_code_o = '0;
    for (int c = 0; c < LVL_N; c++) begin
      if (qual[c]) begin
        any_o      = 1'b1;
        top_code_o = CODE_W'(c);
      end
    end
  end
endmodule

// File: rtl/irq_chain_cell.sv
`timescale 1ns/1ps
module irq_chain_cell
  import irq_arb_pkg::*;
#(
  parameter int unsigned VEC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_N-1:0]  gnt_in_i,
  input  logic              req_i,
  input  logic [CODE_W-1:0] lvl_i,
  input  logic              vld_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [LVL_N-1:0]  gnt_out_o,
  output logic              win_o,
  output logic              hit_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic held_q;
  logic gnt_own;

  assign gnt_own   = gnt_in_i[lvl_i];
  // holder keeps absorbing after its request drops
  assign win_o     = gnt_own && (req_i || held_q);
  assign gnt_out_o = win_o ? (gnt_in_i & ~(LVL_N'(1) << lvl_i)) : gnt_in_i;
  assign hit_o     = win_o && vld_i;
  assign vec_o     = hit_o ? vec_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else         held_q <= win_o;
  end
endmodule

// File: rtl/irq_resp_timer.sv
`timescale 1ns/1ps
module irq_resp_timer #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/irq_chain_arbiter.sv
`timescale 1ns/1ps
module irq_chain_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_DEV   = 4,
  parameter int unsigned VEC_W   = 16,
  parameter int unsigned TIMEOUT = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [PRIO_W-1:0]         cpu_prio_i,
  input  logic [N_DEV-1:0]          dev_req_i,
  input  logic [N_DEV*CODE_W-1:0]   dev_lvl_i,
  input  logic [N_DEV-1:0]          dev_vld_i,
  input  logic [N_DEV*VEC_W-1:0]    dev_vec_i,
  output logic [N_DEV-1:0]          dev_gnt_o,
  output logic [LVL_N-1:0]          grant_o,
  output logic                      vec_valid_o,
  output logic [VEC_W-1:0]          vec_addr_o,
  output logic [PRIO_W-1:0]         vec_lvl_o,
  output logic                      bus_err_o
);
  arb_state_e        state_q;
  logic [CODE_W-1:0] lvl_q;
  logic              any_req;
  logic [CODE_W-1:0] top_code;
  logic [LVL_N-1:0]  line_req;
  logic              expire;
  logic [LVL_N-1:0]  gnt_chain [N_DEV+1];
  logic [N_DEV-1:0]  cell_hit;
  logic [VEC_W-1:0]  cell_vec  [N_DEV];
  logic [LVL_N-1:0]  dev_line  [N_DEV];
  logic              hit_any;
  logic [VEC_W-1:0]  hit_vec;
  logic [LVL_N-1:0]  chain_tail;

  // shared request lines, one per level
  for (genvar d = 0; d < N_DEV; d++) begin : g_line
    assign dev_line[d] = dev_req_i[d] ?
                         (LVL_N'(1) << dev_lvl_i[d*CODE_W +: CODE_W]) : '0;
  end

  always_comb begin
    line_req = '0;
    for (int d = 0; d < N_DEV; d++) line_req |= dev_line[d];
  end

  irq_level_select u_sel (
    .line_req_i (line_req),
    .prio_i     (cpu_prio_i),
    .any_o      (any_req),
    .top_code_o (top_code)
  );

  assign grant_o      = (state_q == ST_GRANT) ? (LVL_N'(1) << lvl_q) : '0;
  assign gnt_chain[0] = grant_o;

  for (genvar d = 0; d < N_DEV; d++) begin : g_cell
    irq_chain_cell #(.VEC_W(VEC_W)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .gnt_in_i  (gnt_chain[d]),
      .req_i     (dev_req_i[d]),
      .lvl_i     (dev_lvl_i[d*CODE_W +: CODE_W]),
      .vld_i     (dev_vld_i[d]),
      .vec_i     (dev_vec_i[d*VEC_W +: VEC_W]),
      .gnt_out_o (gnt_chain[d+1]),
      .win_o     (dev_gnt_o[d]),
      .hit_o     (cell_hit[d]),
      .vec_o     (cell_vec[d])
    );
  end

  assign chain_tail = gnt_chain[N_DEV];

  always_comb begin
    hit_vec = '0;
    for (int d = 0; d < N_DEV; d++) hit_vec |= cell_vec[d];
  end
  assign hit_any = |cell_hit;

  irq_resp_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_GRANT),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lvl_q       <= '0;
      vec_valid_o <= 1'b0;
      bus_err_o   <= 1'b0;
      vec_addr_o  <= '0;
      vec_lvl_o   <= '0;
    end else begin
      vec_valid_o <= 1'b0;
      bus_err_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (any_req) begin
            state_q <= ST_GRANT;
            lvl_q   <= top_code;
          end
        end
        ST_GRANT: begin
          if (hit_any) begin
            vec_valid_o <= 1'b1;
            vec_addr_o  <= hit_vec;
            vec_lvl_o   <= code_to_level(lvl_q);
            state_q     <= ST_IDLE;
          end else if (expire) begin
            vec_valid_o <= 1'b1;
            bus_err_o   <= 1'b1;
            vec_addr_o  <= VEC_W'(BUS_ERR_VEC);
            vec_lvl_o   <= code_to_level(lvl_q);
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_arb_checker.sv
`timescale 1ns/1ps
module irq_arb_checker
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_DEV   = 4,
  parameter int unsigned VEC_W   = 16,
  parameter int unsigned TIMEOUT = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PRIO_W-1:0]  cpu_prio_i,
  input logic [N_DEV-1:0]   dev_vld_i,
  input logic [N_DEV-1:0]   dev_gnt_o,
  input logic [LVL_N-1:0]   grant_o,
  input logic               vec_valid_o,
  input logic [VEC_W-1:0]   vec_addr_o,
  input logic               bus_err_o,
  input logic [LVL_N-1:0]   chain_tail
);
  localparam int unsigned GC_W = $clog2(TIMEOUT + 2) + 1;

  logic [PRIO_W-1:0] g_lvl;
  logic [GC_W-1:0]   gcnt_q;

  always_comb begin
    g_lvl = '0;
    for (int k = 0; k < LVL_N; k++)
      if (grant_o[k]) g_lvl = PRIO_W'(LVL_BASE + k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 gcnt_q <= '0;
    else if (grant_o == '0)      gcnt_q <= '0;
    else if (gcnt_q != '1)       gcnt_q <= gcnt_q + GC_W'(1);
  end

  assert_above_prio_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|grant_o) |-> g_lvl > $past(cpu_prio_i));

  assert_one_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  assert_tail_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_tail != '0) |-> (dev_gnt_o == '0));

  assert_one_holder_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_gnt_o) && ((dev_gnt_o == '0) || (grant_o != '0)));

  assert_vec_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && !bus_err_o) |-> $past(|(dev_gnt_o & dev_vld_i)));

  assert_err_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (vec_valid_o && vec_addr_o == VEC_W'(4) && grant_o == '0));

  assert_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gcnt_q <= GC_W'(TIMEOUT));

  assert_grant_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|$past(grant_o)) && !vec_valid_o) |-> (grant_o == $past(grant_o)));

  assert_gap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (grant_o == '0));
endmodule

bind irq_chain_arbiter irq_arb_checker #(
  .N_DEV(N_DEV), .VEC_W(VEC_W), .TIMEOUT(TIMEOUT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_prio_i  (cpu_prio_i),
  .dev_vld_i   (dev_vld_i),
  .dev_gnt_o   (dev_gnt_o),
  .grant_o     (grant_o),
  .vec_valid_o (vec_valid_o),
  .vec_addr_o  (vec_addr_o),
  .bus_err_o   (bus_err_o),
  .chain_tail  (chain_tail)
);

// File: tb/irq_chain_arbiter_test.sv
`timescale 1ns/1ps
module irq_chain_arbiter_test;
  localparam int unsigned N  = 4;
  localparam int unsigned VW = 16;
  localparam int unsigned TO = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    prio = 3'd7;
  logic [N-1:0]  req = '0;
  logic [1:0]    lvl [N];
  logic [N-1:0]  vld = '0;
  logic [N*2-1:0]  lvl_bus;
  logic [N*VW-1:0] vec_bus;
  logic [N-1:0]  dev_gnt;
  logic [3:0]    grant;
  logic          vec_valid;
  logic [VW-1:0] vec_addr;
  logic [2:0]    vec_lvl;
  logic          bus_err;
  int            compared = 0;
  int            mismatched = 0;
  logic          done = 1'b0;

  always #5 clk = ~clk;

  assign lvl_bus = {lvl[3], lvl[2], lvl[1], lvl[0]};
  assign vec_bus = {16'h004C, 16'h0048, 16'h0044, 16'h0040};

  irq_chain_arbiter #(.N_DEV(N), .VEC_W(VW), .TIMEOUT(TO)) uut (
    .clk_i (clk), .rst_ni (rst_n), .cpu_prio_i (prio),
    .dev_req_i (req), .dev_lvl_i (lvl_bus), .dev_vld_i (vld),
    .dev_vec_i (vec_bus), .dev_gnt_o (dev_gnt), .grant_o (grant),
    .vec_valid_o (vec_valid), .vec_addr_o (vec_addr),
    .vec_lvl_o (vec_lvl), .bus_err_o (bus_err)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic serve(input int d, input logic [2:0] exp_lvl);
    vld[d] = 1'b1;
    step();
    vld[d] = 1'b0;
    req[d] = 1'b0;
    chk("R8 vec_valid", 32'(vec_valid), 32'd1);
    chk("R8 bus_err low", 32'(bus_err), 32'd0);
    chk("R8 vec_addr", 32'(vec_addr), 32'h40 + 32'(4 * d));
    chk("R8 vec_lvl", 32'(vec_lvl), 32'(exp_lvl));
    chk("R11 grant gap", 32'(grant), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 grant", 32'(grant), 0);
    chk("R1 dev_gnt", 32'(dev_gnt), 0);
    chk("R1 vec_valid", 32'(vec_valid), 0);
    chk("R1 bus_err", 32'(bus_err), 0);
  endtask

  task automatic t_threshold();
    prio = 3'd5; lvl[0] = 2'd1; req[0] = 1'b1;
    repeat (3) step();
    chk("R2 level5 at prio5", 32'(grant), 0);
    chk("R2 no holder", 32'(dev_gnt), 0);
    prio = 3'd4;
    step();
    chk("R4 deferred granted", 32'(grant), 32'b0010);
    chk("R4 holder", 32'(dev_gnt), 32'b0001);
    serve(0, 3'd5);
    prio = 3'd7; lvl[3] = 2'd3; req[3] = 1'b1;
    repeat (4) step();
    chk("R2 prio7 blocks", 32'(grant), 0);
    lvl[3] = 2'd0; prio = 3'd3;
    step();
    chk("R2 prio3 level4", 32'(grant), 32'b0001);
    chk("R2 holder", 32'(dev_gnt), 32'b1000);
    serve(3, 3'd4);
    step();
  endtask

  task automatic t_highest();
    prio = 3'd0;
    lvl[0] = 2'd0; lvl[1] = 2'd2; lvl[2] = 2'd3;
    req = 4'b0111;
    step();
    chk("R3 top level", 32'(grant), 32'b1000);
    chk("R3 holder", 32'(dev_gnt), 32'b0100);
    serve(2, 3'd7);
    step();
    chk("R11 next grant", 32'(grant), 32'b0100);
    chk("R3 next holder", 32'(dev_gnt), 32'b0010);
    serve(1, 3'd6);
    step();
    chk("R3 lowest last", 32'(dev_gnt), 32'b0001);
    serve(0, 3'd4);
    step();
  endtask

  task automatic t_chain();
    prio = 3'd4;
    lvl[0] = 2'd0; lvl[2] = 2'd1; lvl[3] = 2'd1;
    req = 4'b1101;
    step();
    chk("R6 level5 line", 32'(grant), 32'b0010);
    chk("R5 R6 nearest same level", 32'(dev_gnt), 32'b0100);
    serve(2, 3'd5);
    step();
    chk("R5 tail slot", 32'(dev_gnt), 32'b1000);
    serve(3, 3'd5);
    prio = 3'd3;
    step();
    chk("R6 remaining head", 32'(dev_gnt), 32'b0001);
    serve(0, 3'd4);
    step();
  endtask

  task automatic t_hold();
    prio = 3'd0; lvl[0] = 2'd1; lvl[1] = 2'd1;
    req = 4'b0011;
    step();
    chk("R7 head wins", 32'(dev_gnt), 32'b0001);
    step();
    req[0] = 1'b0;
    step();
    chk("R7 held after drop", 32'(dev_gnt), 32'b0001);
    chk("R7 line kept", 32'(grant), 32'b0010);
    step();
    chk("R7 still held", 32'(dev_gnt), 32'b0001);
    serve(0, 3'd5);
    step();
    chk("R7 second slot", 32'(dev_gnt), 32'b0010);
    serve(1, 3'd5);
    step();
  endtask

  task automatic t_timeout();
    prio = 3'd0; lvl[2] = 2'd3; req[2] = 1'b1;
    step();
    chk("R9 grant start", 32'(grant), 32'b1000);
    for (int k = 1; k < int'(TO); k++) begin
      step();
      chk("R9 grant held in window", 32'(grant), 32'b1000);
    end
    step();
    chk("R9 bus_err", 32'(bus_err), 1);
    chk("R9 vec_valid", 32'(vec_valid), 1);
    chk("R9 vec 004", 32'(vec_addr), 4);
    chk("R9 released", 32'(grant), 0);
    req[2] = 1'b0;
    step();
    lvl[1] = 2'd2; req[1] = 1'b1;
    step();
    chk("R9 fall-through grant", 32'(dev_gnt), 32'b0010);
    req[1] = 1'b0;
    step();
    chk("R9 nobody holds", 32'(dev_gnt), 0);
    chk("R10 line kept", 32'(grant), 32'b0100);
    repeat (int'(TO) - 2) step();
    chk("R9 last window cycle", 32'(bus_err), 0);
    step();
    chk("R9 fall-through err", 32'(bus_err), 1);
    chk("R9 fall-through vec", 32'(vec_addr), 4);
    step();
  endtask

  task automatic t_prio_rise();
    prio = 3'd4; lvl[3] = 2'd3; req[3] = 1'b1;
    step();
    chk("R10 granted", 32'(grant), 32'b1000);
    prio = 3'd7;
    repeat (2) step();
    chk("R10 kept after prio rise", 32'(grant), 32'b1000);
    chk("R10 holder kept", 32'(dev_gnt), 32'b1000);
    serve(3, 3'd7);
    step();
    chk("R10 no regrant at prio7", 32'(grant), 0);
  endtask

  initial begin
    for (int d = 0; d < int'(N); d++) lvl[d] = 2'd0;
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_threshold();
    t_highest();
    t_chain();
    t_hold();
    t_timeout();
    t_prio_rise();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule